// File: doc/BRIEF.md
# Four-Register Multicycle Processor Core

This block is a minimal register-to-register processor. It reads 16-bit instruction words from a word-addressed instruction memory, using an address that comes from its program counter. It decodes each word into an operation code and three register selectors. It then combines two of its four 16-bit general registers in an internal ALU and writes the result back to a third register. A three-phase controller handles each instruction: fetch, then decode, then execute. After each instruction the program counter moves on by one.

The core has no loads, stores, branches or immediates. Its registers therefore start from a reset value given by a parameter (all zero by default), and a program only transforms those values. The contents of all four registers are brought out on a debug bus so that a program's effect can be observed. The instruction memory must answer a read in the same clock cycle as the address it is given.

Top module: `quad_reg_cpu`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the program counter is cleared to 0, every register Rk is loaded with slice k of the `SEEDS` parameter (all zero by default), and the controller returns to the fetch phase. The first instruction fetched after reset is therefore the one at address 0.
- R2: Every instruction takes exactly three clocks. The word on `imem_rdata` is captured at the first rising edge after `imem_addr` shows its address. `imem_addr` holds its value through the fetch and decode phases. At the third edge `imem_addr` grows by one, and any register write takes effect at that same edge.
- R3: Opcode 2 (bits [15:12]) writes the sum of the two source registers, taken modulo 2^16.
- R4: Opcode 6 writes the first source minus the second source, taken modulo 2^16.
- R5: Opcode 0 writes the bitwise AND of the two source registers.
- R6: Opcode 1 writes the bitwise OR of the two source registers.
- R7: An instruction changes only the register named by its destination field. No register changes during the fetch or decode phases.
- R8: The destination register is selected by bits [9:8] of the instruction, the first source by bits [5:4] and the second source by bits [1:0]. Bits [11:10], [7:6] and [3:2] have no effect.
- R9: Opcodes 3, 4, 5 and 7 to 15 write no register, but the program counter still advances by one.
- R10: The program counter wraps from 2^AW-1 to 0 (from 255 to 0 by default).
- R11: Both sources are read as they stood before the instruction's write-back, even when a source is also the destination. For example, opcode 2 with all three fields naming R1 doubles R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | AW (8) | Instruction memory word address, taken from the program counter |
| imem_rdata | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| dbg_regs | output | 4*DW (64) | Register contents: R0 in bits [15:0] up to R3 in bits [63:48] |

## Verification
The assertions rely on `imem_rdata` being a defined, X-free word that follows `imem_addr` within the same cycle, and on reset being held low for at least one rising edge before it is released. The bench meets this by modelling the instruction memory as a combinational array lookup in which every one of the 256 words is written before reset is released. Reset changes only on falling edges. The result checks compare the debug bus against values computed from register contents that the bench has already checked, so any divergence shows up at the edge where it first happens.

// File: rtl/qrc_pkg.sv
// Package qrc_pkg
// Shared constants and types for the four-register multicycle core:
// instruction layout, opcode values and controller phase encoding.
// Assumes 16-bit instruction words with four 4-bit fields.
package qrc_pkg;

    localparam int INSTR_W  = 16;
    localparam int FIELD_W  = 4;

    // Field start positions inside the instruction word (decoded by neighbours)
    localparam int OP_LSB   = 12;
    localparam int DST_LSB  = 8;
    localparam int SRCA_LSB = 4;
    localparam int SRCB_LSB = 0;

    // Operation codes
    localparam logic [FIELD_W-1:0] OPC_AND = 4'd0;
    localparam logic [FIELD_W-1:0] OPC_OR  = 4'd1;
    localparam logic [FIELD_W-1:0] OPC_ADD = 4'd2;
    localparam logic [FIELD_W-1:0] OPC_SUB = 4'd6;

    // Controller phases
    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    // Instruction view as named fields
    typedef struct packed {
        logic [FIELD_W-1:0] opc;
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] src_a;
        logic [FIELD_W-1:0] src_b;
    } instr_t;

    // True for the four implemented operation codes
    function automatic logic opc_is_defined(input logic [FIELD_W-1:0] opc);
        return (opc == OPC_AND) || (opc == OPC_OR) ||
               (opc == OPC_ADD) || (opc == OPC_SUB);
    endfunction

endpackage

// File: rtl/qrc_sequencer.sv
// Module qrc_sequencer
// Three-phase controller with program counter and instruction register.
// FETCH captures the memory word, DECODE lets the decoded fields settle,
// EXEC commits the write-back and advances the program counter.
// Assumes the instruction memory returns the word combinationally.
module qrc_sequencer
    import qrc_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] mem_word,
    output logic [AW-1:0]      pc,
    output logic [INSTR_W-1:0] ir,
    output phase_e             phase,
    output logic               in_exec
);

    localparam logic [AW-1:0] PC_STEP = AW'(1);

    phase_e             phase_q;
    logic [AW-1:0]      pc_q;
    logic [INSTR_W-1:0] ir_q;

    // Advance the phase machine one step per clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else begin
            unique case (phase_q)
                PH_FETCH:  phase_q <= PH_DECODE;
                PH_DECODE: phase_q <= PH_EXEC;
                PH_EXEC:   phase_q <= PH_FETCH;
                default:   phase_q <= PH_FETCH;
            endcase
        end
    end

    // Capture the addressed memory word at the end of FETCH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (phase_q == PH_FETCH) begin
            ir_q <= mem_word;
        end
    end

    // Step the program counter at the end of EXEC, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (phase_q == PH_EXEC) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    assign pc      = pc_q;
    assign ir      = ir_q;
    assign phase   = phase_q;
    assign in_exec = (phase_q == PH_EXEC);

endmodule

// File: rtl/qrc_decoder.sv
// Module qrc_decoder
// Splits the held instruction into register selectors and an operation,
// and raises the write enable only in EXEC for a defined opcode.
// Assumes NREG is a power of two no larger than 16; only the low
// bits of each register field are used.
module qrc_decoder
    import qrc_pkg::*;
#(
    parameter int NREG  = 4,
    localparam int SEL_W = $clog2(NREG)
) (
    input  logic [INSTR_W-1:0] ir,
    input  logic               in_exec,
    output logic [FIELD_W-1:0] alu_opc,
    output logic [SEL_W-1:0]   wr_sel,
    output logic [SEL_W-1:0]   rd_a_sel,
    output logic [SEL_W-1:0]   rd_b_sel,
    output logic               wr_en
);

    instr_t fields;
    logic   unused_field_hi;

    // View the instruction as named fields and trim register selectors
    always_comb begin
        fields   = instr_t'(ir);
        alu_opc  = fields.opc;
        wr_sel   = fields.dst[SEL_W-1:0];
        rd_a_sel = fields.src_a[SEL_W-1:0];
        rd_b_sel = fields.src_b[SEL_W-1:0];
        wr_en    = in_exec && opc_is_defined(fields.opc);
    end

    generate
        if (SEL_W < FIELD_W) begin : g_hi_bits
            assign unused_field_hi = ^{fields.dst[FIELD_W-1:SEL_W],
                                       fields.src_a[FIELD_W-1:SEL_W],
                                       fields.src_b[FIELD_W-1:SEL_W]};
        end else begin : g_no_hi_bits
            assign unused_field_hi = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/qrc_alu.sv
// Module qrc_alu
// Combinational ALU for the four implemented operations. Results wrap
// modulo 2^DW and no flags are produced. Undefined codes give zero;
// the decoder blocks their write-back.
module qrc_alu
    import qrc_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [FIELD_W-1:0] opc,
    input  logic [DW-1:0]      opnd_a,
    input  logic [DW-1:0]      opnd_b,
    output logic [DW-1:0]      result
);

    // Select the operation named by the opcode
    always_comb begin
        unique case (opc)
            OPC_ADD: result = opnd_a + opnd_b;
            OPC_SUB: result = opnd_a - opnd_b;
            OPC_AND: result = opnd_a & opnd_b;
            OPC_OR:  result = opnd_a | opnd_b;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/qrc_regfile.sv
// Module qrc_regfile
// NREG registers of DW bits with one write port and two read
// multiplexers. Reset loads each register from its SEEDS slice.
// Reads return the value before a same-edge write (registered storage).
module qrc_regfile #(
    parameter int                 DW    = 16,
    parameter int                 NREG  = 4,
    parameter logic [NREG*DW-1:0] SEEDS = '0,
    localparam int                SEL_W = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [SEL_W-1:0]   wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic [SEL_W-1:0]   rd_a_sel,
    input  logic [SEL_W-1:0]   rd_b_sel,
    output logic [DW-1:0]      rd_a,
    output logic [DW-1:0]      rd_b,
    output logic [NREG*DW-1:0] flat
);

    logic [DW-1:0] store_q [NREG];

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_reg
            // Hold register k, reloading its seed on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    store_q[k] <= SEEDS[k*DW +: DW];
                end else if (wr_en && (wr_sel == SEL_W'(k))) begin
                    store_q[k] <= wr_data;
                end
            end
            assign flat[k*DW +: DW] = store_q[k];
        end
    endgenerate

    // Route the two selected registers to the ALU operands
    always_comb begin
        rd_a = store_q[rd_a_sel];
        rd_b = store_q[rd_b_sel];
    end

endmodule

// File: rtl/quad_reg_cpu.sv
// Module quad_reg_cpu
// Top of the four-register multicycle core: sequencer, decoder,
// register file and ALU. One instruction every three clocks.
// Assumes imem_rdata reflects imem_addr within the same cycle.
module quad_reg_cpu
    import qrc_pkg::*;
#(
    parameter int                 AW    = 8,
    parameter int                 DW    = 16,
    parameter int                 NREG  = 4,
    parameter logic [NREG*DW-1:0] SEEDS = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [AW-1:0]        imem_addr,
    input  logic [INSTR_W-1:0]   imem_rdata,
    output logic [NREG*DW-1:0]   dbg_regs
);

    localparam int SEL_W = $clog2(NREG);

    logic [INSTR_W-1:0] ir_w;
    phase_e             phase_w;
    logic               in_exec_w;
    logic [FIELD_W-1:0] opc_w;
    logic [SEL_W-1:0]   wr_sel_w, rd_a_sel_w, rd_b_sel_w;
    logic               wr_en_w;
    logic [DW-1:0]      opnd_a_w, opnd_b_w, result_w;

    qrc_sequencer #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_word (imem_rdata),
        .pc       (imem_addr),
        .ir       (ir_w),
        .phase    (phase_w),
        .in_exec  (in_exec_w)
    );

    qrc_decoder #(.NREG(NREG)) u_dec (
        .ir       (ir_w),
        .in_exec  (in_exec_w),
        .alu_opc  (opc_w),
        .wr_sel   (wr_sel_w),
        .rd_a_sel (rd_a_sel_w),
        .rd_b_sel (rd_b_sel_w),
        .wr_en    (wr_en_w)
    );

    qrc_regfile #(.DW(DW), .NREG(NREG), .SEEDS(SEEDS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en_w),
        .wr_sel   (wr_sel_w),
        .wr_data  (result_w),
        .rd_a_sel (rd_a_sel_w),
        .rd_b_sel (rd_b_sel_w),
        .rd_a     (opnd_a_w),
        .rd_b     (opnd_b_w),
        .flat     (dbg_regs)
    );

    qrc_alu #(.DW(DW)) u_alu (
        .opc    (opc_w),
        .opnd_a (opnd_a_w),
        .opnd_b (opnd_b_w),
        .result (result_w)
    );

endmodule

// File: rtl/qrc_checker.sv
// Module qrc_checker
// Property checks for quad_reg_cpu, attached by bind below. Watches the
// program counter, the register bus, the phase and the held instruction.
module qrc_checker
    import qrc_pkg::*;
#(
    parameter int                 AW    = 8,
    parameter int                 DW    = 16,
    parameter int                 NREG  = 4,
    parameter logic [NREG*DW-1:0] SEEDS = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [AW-1:0]      pc,
    input logic [NREG*DW-1:0] regs,
    input logic [1:0]         phase,
    input logic [INSTR_W-1:0] instr
);

    localparam int SEL_W = $clog2(NREG);

    logic               was_rst;
    logic [SEL_W-1:0]   dst, sa, sb;
    logic [FIELD_W-1:0] opc;
    logic [DW-1:0]      val_a, val_b, val_d;
    logic               exec_now;

    // Remember whether the previous edge saw reset
    always_ff @(posedge clk) was_rst <= !rst_n;

    // Pick out fields and current operand values
    always_comb begin
        opc      = instr[OP_LSB +: FIELD_W];
        dst      = instr[DST_LSB +: SEL_W];
        sa       = instr[SRCA_LSB +: SEL_W];
        sb       = instr[SRCB_LSB +: SEL_W];
        val_a    = regs[sa*DW +: DW];
        val_b    = regs[sb*DW +: DW];
        val_d    = regs[dst*DW +: DW];
        exec_now = (phase == PH_EXEC);
    end

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (pc == '0) && (regs == SEEDS) && (phase == PH_FETCH));

    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (phase == PH_DECODE));

    a_r2_exec_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DECODE) |=> exec_now);

    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_now |=> $stable(pc));

    // Covers R10 too: the step is taken modulo 2^AW
    a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        exec_now |=> (pc == AW'($past(pc) + 1'b1)));

    a_r7_quiet_outside_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_now |=> $stable(regs));

    a_r9_undefined_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && !opc_is_defined(opc)) |=> $stable(regs));

    a_r3_add_result: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && opc == OPC_ADD) |=> (val_d == DW'($past(val_a) + $past(val_b))));

    a_r4_sub_result: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_now && opc == OPC_SUB) |=> (val_d == DW'($past(val_a) - $past(val_b))));

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_keep
            a_r7_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (exec_now && dst != SEL_W'(k)) |=> $stable(regs[k*DW +: DW]));
        end
    endgenerate

endmodule

bind quad_reg_cpu qrc_checker #(
    .AW(AW), .DW(DW), .NREG(NREG), .SEEDS(SEEDS)
) u_qrc_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .pc    (imem_addr),
    .regs  (dbg_regs),
    .phase (phase_w),
    .instr (ir_w)
);

// File: tb/quad_reg_cpu_tb_top.sv
// Bench for quad_reg_cpu: behavioural reference model stepped on every
// rising edge, compared against the ports on every falling edge.
module quad_reg_cpu_tb_top;

    localparam int          AW    = 8;
    localparam int          DW    = 16;
    localparam int          DEPTH = 256;
    localparam logic [63:0] SEED_V = 64'h00F0_8001_FFFF_1234;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [15:0]   imem_rdata;
    logic [63:0]   dbg_regs;

    logic [15:0] mem [DEPTH];
    string       tags [DEPTH];

    int checks = 0;
    int failures = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;

    // reference model state
    int          pc_m = 0;
    int          ph_m = 0;
    logic [15:0] r_m [4];
    logic [15:0] ir_m = '0;
    string       tag_cur = "R1";
    bit          wrapped = 1'b0;

    always #4 clk = ~clk;

    assign imem_rdata = mem[imem_addr];

    quad_reg_cpu #(.AW(AW), .DW(DW), .NREG(4), .SEEDS(SEED_V)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dbg_regs   (dbg_regs)
    );

    function automatic logic [15:0] enc(int op, int d, int a, int b);
        return {4'(op), 4'(d), 4'(a), 4'(b)};
    endfunction

    // program: directed part then generated filler
    initial begin
        mem[0]  = enc(2, 0, 1, 2);    tags[0]  = "R3,R7";   // FFFF+8001 wraps
        mem[1]  = enc(6, 3, 0, 1);    tags[1]  = "R4,R7";   // borrow wrap
        mem[2]  = enc(0, 2, 1, 3);    tags[2]  = "R5,R7";
        mem[3]  = enc(1, 1, 0, 2);    tags[3]  = "R6,R7";
        mem[4]  = enc(2, 1, 1, 1);    tags[4]  = "R11";
        mem[5]  = enc(6, 2, 3, 3);    tags[5]  = "R11";
        mem[6]  = enc(15, 0, 1, 2);   tags[6]  = "R9";
        mem[7]  = enc(3, 1, 0, 0);    tags[7]  = "R9";
        mem[8]  = enc(7, 2, 0, 0);    tags[8]  = "R9";
        mem[9]  = enc(2, 13, 6, 11);  tags[9]  = "R8";      // R1 = R2 + R3
        mem[10] = enc(1, 14, 15, 12); tags[10] = "R8";      // R2 = R3 | R0
        mem[11] = enc(6, 0, 3, 1);    tags[11] = "R4";
        mem[12] = enc(0, 3, 0, 2);    tags[12] = "R5";
        for (int i = 13; i < DEPTH; i++) begin
            int sel;
            int opv;
            sel = i % 5;
            opv = (sel == 0) ? 2 : (sel == 1) ? 6 : (sel == 2) ? 0 :
                  (sel == 3) ? 1 : ((i % 2) ? 10 : 5);
            mem[i] = enc(opv, ((i >> 4) % 4) * 4 + (i / 5) % 4,
                         (i % 4) + 4 * (i % 3), (i / 3) % 4);
            tags[i] = (sel == 4) ? "R9" : "R2,R7";
        end
    end

    // reference model: one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            pc_m = 0;
            ph_m = 0;
            for (int k = 0; k < 4; k++) r_m[k] = SEED_V[k*16 +: 16];
            tag_cur = "R1";
            chk_en = 1'b1;
        end else begin
            case (ph_m)
                0: begin ir_m = mem[pc_m]; ph_m = 1; end
                1: ph_m = 2;
                default: begin
                    int d, a, b;
                    d = ir_m[9:8]; a = ir_m[5:4]; b = ir_m[1:0];
                    case (ir_m[15:12])
                        4'd2: r_m[d] = r_m[a] + r_m[b];
                        4'd6: r_m[d] = r_m[a] - r_m[b];
                        4'd0: r_m[d] = r_m[a] & r_m[b];
                        4'd1: r_m[d] = r_m[a] | r_m[b];
                        default: ;
                    endcase
                    tag_cur = tags[pc_m];
                    pc_m = (pc_m + 1) % DEPTH;
                    if (pc_m == 0) wrapped = 1'b1;
                    ph_m = 0;
                end
            endcase
        end
    end

    // compare ports with the model away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            string ptag;
            ptag = (wrapped && pc_m == 0) ? "R10" : "R2";
            checks++;
            if (imem_addr !== AW'(pc_m)) begin
                failures++;
                $display("FAIL %s pc actual=%0d expected=%0d", ptag, imem_addr, pc_m);
            end
            for (int k = 0; k < 4; k++) begin
                checks++;
                if (dbg_regs[k*16 +: 16] !== r_m[k]) begin
                    failures++;
                    $display("FAIL %s reg%0d actual=%h expected=%h",
                             tag_cur, k, dbg_regs[k*16 +: 16], r_m[k]);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // stimulus: reset, long run past address wrap, reset mid-instruction
    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (800) @(posedge clk);
        @(negedge clk) rst_n = 1'b0;          // R1 again, mid-instruction
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        repeat (60) @(posedge clk);
        @(negedge clk);
        if (!wrapped) begin
            checks++;
            failures++;
            $display("FAIL R10 wrap actual=0 expected=1");
        end
        finish_run();
    end

    // watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule